// File: doc/BRIEF.md
# Bus Yield Arbiter

The bus yield arbiter lets a second bus master borrow the external memory bus. A master raises a hold request. The arbiter brings that request into the local clock domain and stops the bus sequencer from opening new cycles. It then waits for a legal cycle boundary, raises an acknowledge and turns off the address/data pin drivers. While the bus is away, the read, write, latch-enable, byte-enable and fetch-type strobes are only weakly held inactive. If the core has an external access queued during that time, a bus-request output tells the other master that work is waiting.

The release latency follows the bus mode. With internal execution the bus is already free. A 16-bit external access ends after one cycle. An 8-bit external access of a word is split into two chained byte cycles, and the bus cannot be handed over between them. When the hold request is withdrawn, the arbiter drops the acknowledge and restores the pin drivers. It then holds off new cycles for one more clock, so that address and strobes are valid before the next address strobe.

All handshake pins are active-high.

Top module: `bus_yield_arbiter`

## Requirements
- R1: After reset the acknowledge is 0, the bus-request output is 0, every address/data and strobe output enable is 1, every weak-hold enable is 0, and cycle start is permitted while the hold request is low.
- R2: The hold request passes through SYNC_STAGES (default 2) flip-flops. With no bus cycle active, the acknowledge rises on the (SYNC_STAGES+1)-th rising edge after the hold request goes high (edge 3 by default) and not before.
- R3: Cycle start is refused whenever the synchronised hold request is high, and in every state other than core ownership.
- R4: The acknowledge rises only on an edge where, in the cycle before it, either no bus cycle was active or the active cycle was in its final clock with no chained follow-on cycle. A 16-bit access is released on the edge that closes it.
- R5: A final clock flagged as chained (first byte of a split 8-bit access) is not a release point. Release waits for the final clock of the unchained second half.
- R6: While the acknowledge is high, all address/data output enables and strobe output enables are 0 and all strobe weak-hold enables are 1.
- R7: The bus-request output is high exactly when the bus is held and the core reports an access pending, updated on the next edge. It is 0 whenever the bus is not held.
- R8: After the hold request falls, the acknowledge and bus-request outputs fall on the (SYNC_STAGES+1)-th edge (edge 3 by default). All output enables return to 1 on that same edge, and cycle start stays refused for one further clock.
- R9: A hold request withdrawn before release returns the arbiter to core ownership without any acknowledge pulse. Cycle start is permitted again SYNC_STAGES+1 edges after the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_i | input | 1 | Hold request from the other master, asynchronous |
| cyc_active_i | input | 1 | Sequencer has an external bus cycle in progress |
| cyc_end_i | input | 1 | Current clock is the final clock of the active cycle |
| cyc_chain_i | input | 1 | The ending cycle is followed by a linked second half |
| access_pending_i | input | 1 | Core has an external access queued |
| hold_ack_o | output | 1 | Bus released to the other master |
| bus_req_o | output | 1 | Core wants the bus back while it is held |
| cyc_start_ok_o | output | 1 | Sequencer may open a new bus cycle |
| ad_oe_o | output | AD_WIDTH | Address/data pin driver enables |
| strobe_oe_o | output | NUM_STROBES | Strong driver enables for the control strobes |
| strobe_keep_o | output | NUM_STROBES | Weak inactive-hold enables for the control strobes |

## Verification
A state machine stuck in the draining state shows at the ports as an acknowledge that never rises after the cycle ends. An early release shows as an acknowledge rising while a cycle, or a chained byte pair, is still open, one edge after the wrong boundary. A lost reclaim step shows as cycle start being allowed on the same clock the acknowledge falls. Driver-enable or bus-request registers out of step with the state differ from the acknowledge on the very edge it changes. A synchroniser of the wrong depth moves both acknowledge edges by whole clocks.

// File: rtl/byarb_pkg.sv
package byarb_pkg;

    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_YIELD   = 2'd2,
        ST_RECLAIM = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       ack;
    } fsm_regs_t;

    typedef struct packed {
        logic ad_oe;
        logic strobe_oe;
        logic strobe_keep;
        logic breq;
    } drv_regs_t;

endpackage

// File: rtl/byarb_sync.sv
module byarb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/byarb_fsm.sv
module byarb_fsm
    import byarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s_i,
    input  logic cyc_active_i,
    input  logic cyc_end_i,
    input  logic cyc_chain_i,
    output logic yield_next_o,
    output logic hold_ack_o,
    output logic cyc_start_ok_o
);
    fsm_regs_t r_d, r_q;
    logic      boundary;

    always_comb begin
        r_d      = r_q;
        boundary = !cyc_active_i || (cyc_end_i && !cyc_chain_i);
        unique case (r_q.state)
            ST_OWN:     if (hold_s_i) r_d.state = boundary ? ST_YIELD : ST_DRAIN;
            ST_DRAIN:   if (!hold_s_i)    r_d.state = ST_OWN;
                        else if (boundary) r_d.state = ST_YIELD;
            ST_YIELD:   if (!hold_s_i) r_d.state = ST_RECLAIM;
            ST_RECLAIM: r_d.state = ST_OWN;
            default:    r_d.state = ST_OWN;
        endcase
        r_d.ack = (r_d.state == ST_YIELD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OWN;
            r_q.ack   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign yield_next_o   = r_d.ack;
    assign hold_ack_o     = r_q.ack;
    assign cyc_start_ok_o = (r_q.state == ST_OWN) && !hold_s_i;

    // R4 / R5: release only follows a legal, unchained boundary
    assert_release_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_o) |-> $past(!cyc_active_i || (cyc_end_i && !cyc_chain_i)));

    assert_no_start_while_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_o |-> !cyc_start_ok_o);

    assert_reclaim_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_o) |-> !cyc_start_ok_o);
endmodule

// File: rtl/byarb_drive.sv
module byarb_drive
    import byarb_pkg::*;
#(
    parameter int AD_WIDTH    = 16,
    parameter int NUM_STROBES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   yield_next_i,
    input  logic                   access_pending_i,
    output logic [AD_WIDTH-1:0]    ad_oe_o,
    output logic [NUM_STROBES-1:0] strobe_oe_o,
    output logic [NUM_STROBES-1:0] strobe_keep_o,
    output logic                   bus_req_o
);
    drv_regs_t r_d, r_q;

    always_comb begin
        r_d.ad_oe       = !yield_next_i;
        r_d.strobe_oe   = !yield_next_i;
        r_d.strobe_keep = yield_next_i;
        r_d.breq        = yield_next_i && access_pending_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ad_oe       <= 1'b1;
            r_q.strobe_oe   <= 1'b1;
            r_q.strobe_keep <= 1'b0;
            r_q.breq        <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ad_oe_o       = {AD_WIDTH{r_q.ad_oe}};
    assign strobe_oe_o   = {NUM_STROBES{r_q.strobe_oe}};
    assign strobe_keep_o = {NUM_STROBES{r_q.strobe_keep}};
    assign bus_req_o     = r_q.breq;
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int AD_WIDTH    = 16,
    parameter int NUM_STROBES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold_req_i,
    input  logic                   cyc_active_i,
    input  logic                   cyc_end_i,
    input  logic                   cyc_chain_i,
    input  logic                   access_pending_i,
    output logic                   hold_ack_o,
    output logic                   bus_req_o,
    output logic                   cyc_start_ok_o,
    output logic [AD_WIDTH-1:0]    ad_oe_o,
    output logic [NUM_STROBES-1:0] strobe_oe_o,
    output logic [NUM_STROBES-1:0] strobe_keep_o
);
    logic hold_s;
    logic yield_next;

    byarb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hold_req_i),
        .q_o   (hold_s)
    );

    byarb_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .hold_s_i       (hold_s),
        .cyc_active_i   (cyc_active_i),
        .cyc_end_i      (cyc_end_i),
        .cyc_chain_i    (cyc_chain_i),
        .yield_next_o   (yield_next),
        .hold_ack_o     (hold_ack_o),
        .cyc_start_ok_o (cyc_start_ok_o)
    );

    byarb_drive #(.AD_WIDTH(AD_WIDTH), .NUM_STROBES(NUM_STROBES)) u_drive (
        .clk              (clk),
        .rst_n            (rst_n),
        .yield_next_i     (yield_next),
        .access_pending_i (access_pending_i),
        .ad_oe_o          (ad_oe_o),
        .strobe_oe_o      (strobe_oe_o),
        .strobe_keep_o    (strobe_keep_o),
        .bus_req_o        (bus_req_o)
    );

    assert_float_when_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_o |-> (ad_oe_o == '0 && strobe_oe_o == '0 && strobe_keep_o == '1));

    assert_driven_when_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_o |-> (ad_oe_o == '1 && strobe_oe_o == '1 && strobe_keep_o == '0));

    assert_breq_only_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> hold_ack_o);
endmodule

// File: tb/sim_bus_yield_arbiter.sv
module sim_bus_yield_arbiter;
    localparam int ADW = 16;
    localparam int NS  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0, cyc_active = 1'b0, cyc_end = 1'b0, cyc_chain = 1'b0, pending = 1'b0;
    logic hold_ack, bus_req, start_ok;
    logic [ADW-1:0] ad_oe;
    logic [NS-1:0]  strobe_oe, strobe_keep;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bus_yield_arbiter #(.SYNC_STAGES(2), .AD_WIDTH(ADW), .NUM_STROBES(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_req_i(hold_req), .cyc_active_i(cyc_active),
        .cyc_end_i(cyc_end), .cyc_chain_i(cyc_chain), .access_pending_i(pending),
        .hold_ack_o(hold_ack), .bus_req_o(bus_req), .cyc_start_ok_o(start_ok),
        .ad_oe_o(ad_oe), .strobe_oe_o(strobe_oe), .strobe_keep_o(strobe_keep)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        hold_req = 1'b0;
        step(4);
    endtask

    task automatic t_reset();
        chk("R1 ack", hold_ack, 0);
        chk("R1 breq", bus_req, 0);
        chk("R1 ad_oe", ad_oe, 16'hFFFF);
        chk("R1 strobe_oe", strobe_oe, 5'h1F);
        chk("R1 keep", strobe_keep, 0);
        chk("R1 start_ok", start_ok, 1);
        pending = 1'b1;
        step(1);
        chk("R7 breq not held", bus_req, 0);
        pending = 1'b0;
    endtask

    task automatic t_idle_grant();
        hold_req = 1'b1;
        step(2);
        chk("R2 ack early", hold_ack, 0);
        chk("R3 start refused", start_ok, 0);
        step(1);
        chk("R2 ack", hold_ack, 1);
        chk("R6 ad_oe", ad_oe, 0);
        chk("R6 strobe_oe", strobe_oe, 0);
        chk("R6 keep", strobe_keep, 5'h1F);
        chk("R7 breq idle", bus_req, 0);
        pending = 1'b1;
        step(1);
        chk("R7 breq pending", bus_req, 1);
        hold_req = 1'b0;
        step(2);
        chk("R8 ack still", hold_ack, 1);
        step(1);
        chk("R8 ack fall", hold_ack, 0);
        chk("R8 breq fall", bus_req, 0);
        chk("R8 ad_oe", ad_oe, 16'hFFFF);
        chk("R8 keep", strobe_keep, 0);
        chk("R8 gap", start_ok, 0);
        step(1);
        chk("R8 resume", start_ok, 1);
        pending = 1'b0;
    endtask

    task automatic t_word16();
        cyc_active = 1'b1;
        hold_req   = 1'b1;
        step(4);
        chk("R4 no mid-cycle", hold_ack, 0);
        chk("R3 draining refuses", start_ok, 0);
        cyc_end = 1'b1;
        step(1);
        chk("R4 at boundary", hold_ack, 1);
        cyc_active = 1'b0;
        cyc_end    = 1'b0;
        release_bus();
        chk("R4 back", start_ok, 1);
    endtask

    task automatic t_byte8();
        cyc_active = 1'b1;
        hold_req   = 1'b1;
        step(3);
        cyc_end   = 1'b1;
        cyc_chain = 1'b1;
        step(1);
        chk("R5 chained end", hold_ack, 0);
        cyc_end   = 1'b0;
        cyc_chain = 1'b0;
        step(1);
        chk("R5 second half", hold_ack, 0);
        cyc_end = 1'b1;
        step(1);
        chk("R5 release", hold_ack, 1);
        cyc_active = 1'b0;
        cyc_end    = 1'b0;
        release_bus();
    endtask

    task automatic t_withdraw();
        cyc_active = 1'b1;
        hold_req   = 1'b1;
        step(3);
        hold_req = 1'b0;
        step(2);
        chk("R9 still draining", start_ok, 0);
        chk("R9 no ack", hold_ack, 0);
        step(1);
        chk("R9 owned", start_ok, 1);
        chk("R9 no ack after", hold_ack, 0);
        cyc_active = 1'b0;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_idle_grant();
        t_word16();
        t_byte8();
        t_withdraw();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule